// File: doc/BRIEF.md
# Funnel Shifter with Rotate

This block shifts or rotates a 32-bit word by 0 to 31 places in one combinational pass. Every operation goes through the same datapath. A 64-bit value is formed from an upper word and a lower word. A 32-bit window is then taken from it, starting at a bit offset counted from the right.

The operation code changes only what is loaded into the two words and the offset:

- **Logical right shift:** zeros go in the upper word.
- **Arithmetic right shift:** copies of the sign bit go in the upper word.
- **Rotate right:** the operand goes in both words.
- **Left shift:** the operand goes in the upper word, zeros go in the lower word, and the offset is the word width minus the amount.

The window is taken by a cascade of 2:1 multiplexer stages. Each stage is steered by one offset bit and moves the data by a power of two. The block has no clock and no storage, so a surrounding pipeline can place it between any pair of registers.

Top module: `funnel_shifter`

## Requirements
- R1: With op_i = 2'b01 (logical right), result_o equals operand_i shifted right by amount_i, and the vacated upper bits are 0.
- R2: With op_i = 2'b10 (arithmetic right), result_o equals operand_i shifted right by amount_i, and the vacated upper bits are copies of operand_i[31].
- R3: With op_i = 2'b11 (rotate right), result_o equals operand_i rotated right by amount_i. Bits leaving bit 0 re-enter at bit 31, and the number of set bits is preserved.
- R4: With op_i = 2'b00 (logical left), result_o equals operand_i shifted left by amount_i, and the vacated lower bits are 0.
- R5: With amount_i = 0, result_o equals operand_i for every op_i value.
- R6: The largest amount, 31, leaves only one operand bit in the result for the shifts: bit 31 moved to bit 0 for the right shifts, or bit 0 moved to bit 31 for the left shift. For the arithmetic shift the result is all copies of the sign bit.
- R7: result_o depends only on the present inputs and settles within the same clock period as an input change, with no clock or reset involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Word to be shifted or rotated |
| amount_i | input | 5 | Shift or rotate distance, 0 to 31 |
| op_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| result_o | output | 32 | Shifted or rotated word |

## Verification
The operands used are:

- a lone set bit 31;
- all ones;
- a mixed pattern;
- random words.

A lone set bit 31 separates logical from arithmetic right shifts, because the two differ only in the fill. All ones exposes a fill that is wrong on either side of the window. Rotate tells apart a funnel that wraps bits around from one that drops them.

Amounts 0, 1, 16 and 31 exercise each end of every multiplexer stage, including the offset of 32 that a left shift by zero produces. Random amounts then mix the stages together.

// File: rtl/fsh_pkg.sv
// Shared definitions for the funnel shifter.
// Assumes a two-bit operation code; the encoding is fixed by the port contract.
package fsh_pkg;
    typedef enum logic [1:0] {
        OP_SLL = 2'b00,
        OP_SRL = 2'b01,
        OP_SRA = 2'b10,
        OP_ROR = 2'b11
    } shop_e;
endpackage

// File: rtl/fsh_stage.sv
// One multiplexer level of the window extractor.
// Passes either the low OUT_W bits or the bits starting STEP places higher.
// Assumes IN_W = OUT_W + STEP so that every input bit feeds one path.
module fsh_stage #(
    parameter int OUT_W = 32,
    parameter int STEP  = 1,
    localparam int IN_W = OUT_W + STEP
) (
    input  logic [IN_W-1:0]  data_i,
    input  logic             sel_i,
    output logic [OUT_W-1:0] data_o
);
    // Select between shifted and unshifted slice.
    always_comb begin
        data_o = sel_i ? data_i[STEP +: OUT_W] : data_i[OUT_W-1:0];
    end
endmodule

// File: rtl/fsh_prep.sv
// Operand steering for the funnel.
// Builds the upper word, the lower word and the offset for each operation.
// Assumes WIDTH is a power of two; the offset carries one extra bit so that a
// left shift by zero maps to an offset equal to WIDTH.
module fsh_prep
    import fsh_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH),
    localparam int OFFW = SHW + 1
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [SHW-1:0]   amount_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] upper_o,
    output logic [WIDTH-1:0] lower_o,
    output logic [OFFW-1:0]  offset_o
);
    localparam logic [OFFW-1:0] FULL = OFFW'(WIDTH);

    // Choose the funnel inputs from the operation code.
    always_comb begin
        upper_o  = '0;
        lower_o  = operand_i;
        offset_o = {1'b0, amount_i};
        unique case (shop_e'(op_i))
            OP_SLL: begin
                upper_o  = operand_i;
                lower_o  = '0;
                offset_o = FULL - {1'b0, amount_i};
            end
            OP_SRL: upper_o = '0;
            OP_SRA: upper_o = {WIDTH{operand_i[WIDTH-1]}};
            OP_ROR: upper_o = operand_i;
            default: upper_o = '0;
        endcase
    end
endmodule

// File: rtl/fsh_extract.sv
// Right-extracting window core.
// Concatenates upper and lower words, then takes WIDTH bits starting at the
// offset through one 2:1 multiplexer level per offset bit, largest step first.
// Each level is only as wide as later levels still need.
module fsh_extract #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH),
    localparam int OFFW = SHW + 1,
    localparam int PADW = WIDTH + 2**OFFW - 1
) (
    input  logic [WIDTH-1:0] upper_i,
    input  logic [WIDTH-1:0] lower_i,
    input  logic [OFFW-1:0]  offset_i,
    output logic [WIDTH-1:0] window_o
);
    logic [PADW-1:0] padded;

    // Zero-extend the 2*WIDTH funnel to the first level's input width.
    always_comb begin
        padded = {{(PADW - 2*WIDTH){1'b0}}, upper_i, lower_i};
    end

    for (genvar b = SHW; b >= 0; b--) begin : g_stage
        localparam int OW = WIDTH + 2**b - 1;
        logic [OW-1:0] o;
        if (b == SHW) begin : g_first
            fsh_stage #(.OUT_W(OW), .STEP(2**b)) u_stage (
                .data_i (padded),
                .sel_i  (offset_i[b]),
                .data_o (o)
            );
        end else begin : g_next
            fsh_stage #(.OUT_W(OW), .STEP(2**b)) u_stage (
                .data_i (g_stage[b+1].o),
                .sel_i  (offset_i[b]),
                .data_o (o)
            );
        end
    end

    // Last level leaves exactly WIDTH bits.
    always_comb begin
        window_o = g_stage[0].o;
    end
endmodule

// File: rtl/funnel_shifter.sv
// Combinational shifter and rotator built on one right-extracting funnel.
// Operation code: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right.
// Assumes WIDTH is a power of two. No clock, reset or storage.
module funnel_shifter
    import fsh_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH),
    localparam int OFFW = SHW + 1
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [SHW-1:0]   amount_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] result_o
);
    logic [WIDTH-1:0] upper_w;
    logic [WIDTH-1:0] lower_w;
    logic [OFFW-1:0]  offset_w;

    fsh_prep #(.WIDTH(WIDTH)) u_prep (
        .operand_i (operand_i),
        .amount_i  (amount_i),
        .op_i      (op_i),
        .upper_o   (upper_w),
        .lower_o   (lower_w),
        .offset_o  (offset_w)
    );

    fsh_extract #(.WIDTH(WIDTH)) u_extract (
        .upper_i  (upper_w),
        .lower_i  (lower_w),
        .offset_i (offset_w),
        .window_o (result_o)
    );

    // Output-level checks against the operand at the ports.
    always_comb begin
        // R1
        srl_topfill_chk: assert (!(op_i == OP_SRL && amount_i != '0) || result_o[WIDTH-1] == 1'b0);
        // R2
        sra_signkeep_chk: assert (op_i != OP_SRA || result_o[WIDTH-1] == operand_i[WIDTH-1]);
        // R3
        ror_popcount_chk: assert (op_i != OP_ROR || $countones(result_o) == $countones(operand_i));
        // R4
        sll_lowfill_chk: assert (!(op_i == OP_SLL && amount_i != '0) || result_o[0] == 1'b0);
        // R5
        zero_amount_chk: assert (amount_i != '0 || result_o == operand_i);
    end
endmodule

// File: tb/funnel_shifter_tb_top.sv
module funnel_shifter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand;
    logic [4:0]  amount;
    logic [1:0]  op;
    logic [31:0] result;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    funnel_shifter dut_i (
        .operand_i (operand),
        .amount_i  (amount),
        .op_i      (op),
        .result_o  (result)
    );

    function automatic logic [31:0] model(input logic [31:0] v, input logic [4:0] s,
                                          input logic [1:0] o);
        case (o)
            2'b00:   return v << s;
            2'b01:   return v >> s;
            2'b10:   return 32'($signed(v) >>> s);
            default: return (v >> s) | (v << (6'd32 - {1'b0, s}));
        endcase
    endfunction

    task automatic apply(input logic [31:0] v, input logic [4:0] s, input logic [1:0] o,
                         input string req);
        logic [31:0] exp;
        @(negedge clk);
        operand = v; amount = s; op = o;
        #1;
        exp = model(v, s, o);
        total++;
        if (result !== exp) begin
            bad++;
            $display("FAIL %s op=%0d amt=%0d opnd=%h got=%h exp=%h", req, o, s, v, result, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [3];
        void'($urandom(32'd1234));
        pats[0] = 32'h8000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h1234_5678;
        operand = '0; amount = '0; op = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R7: reset-state inputs give a zero word at once
        #1; total++;
        if (result !== 32'h0) begin bad++; $display("FAIL R7 got=%h exp=%h", result, 32'h0); end
        // R5: zero amount is identity for each op
        for (int o = 0; o < 4; o++)
            for (int p = 0; p < 3; p++) apply(pats[p], 5'd0, 2'(o), "R5");
        // R6: extreme amount
        apply(32'h8000_0000, 5'd31, 2'b01, "R6");
        apply(32'h8000_0000, 5'd31, 2'b10, "R6");
        apply(32'h0000_0001, 5'd31, 2'b00, "R6");
        apply(32'h7FFF_FFFF, 5'd31, 2'b10, "R6");
        // R1, R2, R3, R4 directed
        for (int p = 0; p < 3; p++) begin
            apply(pats[p], 5'd1,  2'b01, "R1");
            apply(pats[p], 5'd16, 2'b01, "R1");
            apply(pats[p], 5'd1,  2'b10, "R2");
            apply(pats[p], 5'd16, 2'b10, "R2");
            apply(pats[p], 5'd1,  2'b11, "R3");
            apply(pats[p], 5'd31, 2'b11, "R3");
            apply(pats[p], 5'd1,  2'b00, "R4");
            apply(pats[p], 5'd16, 2'b00, "R4");
        end
        // R7: random mix, each result checked in the same cycle as its inputs
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] o;
            o = 2'($urandom);
            apply($urandom, 5'($urandom), o,
                  o == 2'b00 ? "R4" : o == 2'b01 ? "R1" : o == 2'b10 ? "R2" : "R3");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule